// File: doc/BRIEF.md
# Calendar Real-Time Clock with Alarm and Periodic Tick

This block keeps the time of day and the calendar date in BCD. It runs from a slow timekeeping clock (`rtc_clk`, nominally 32.768 kHz) and is programmed from a faster system clock through a word-addressed write/read port. A prescaler divides `rtc_clk` down to one-second steps. The seconds, minutes and hours cascade into day, month and year. Month lengths and leap years are handled, and hours can be shown in 24-hour or 12-hour form. A day-of-week counter advances with the date.

The core is held in its reset state until software writes a 32-bit unlock key. From then on it stays active. Writes to timekeeping state pass through a toggle-and-synchronizer path into the `rtc_clk` domain. They land a fixed two `rtc_clk` edges after capture. Loaded values are stored exactly as written, with no range check.

Two sticky event flags are provided. The alarm flag is set when the clock steps onto a programmed time and date. The tick flag is set at a selectable power-of-two fraction of a second. Each flag drives its own interrupt output, gated by an enable. A bank of general-purpose spare words sits in the system clock domain.

Top module: `rtc_calendar`

## Requirements
- R1: After reset, bit 0 of word 0 (the unlock/status word) reads 0. It reads 1 once the value 0xA5EB1357 has been written to word 0. Any other value leaves it at 0. Once set, it stays 1 whatever is written afterwards.
- R2: While the block is locked, writes to words 1 to 9 are ignored, and the time and date do not advance. The time and date read as 00:00:00 and 00-01-01.
- R3: A write to words 0 to 9 is captured on a `sys_clk` rising edge. It takes effect on the second `rtc_clk` rising edge after that edge, and not on the first. A time load also restarts the current second.
- R4: Time is word 1: hours [23:16], minutes [15:8], seconds [7:0], each two BCD digits. The time steps once every TICKS_PER_SEC `rtc_clk` edges. Seconds and minutes wrap from 59 to 00 with carry. In 24-hour mode, hours wrap from 23 to 00 and advance the date.
- R5: Word 5 bit 0 selects the hour mode (1 = 24-hour, the reset value). In 12-hour mode, hour bit 5 is the PM flag and bits [4:0] hold 01 to 12. The sequence 11 AM→12 PM→01 PM holds, 12 AM→01 AM holds, and 11 PM→12 AM advances the date.
- R6: Date is word 2: year [23:16] (00–99), month [15:8], day [7:0], in BCD. A day past the month's last day goes to 01 and advances the month. Month 12 goes to 01 and advances the year, and year 99 wraps to 00. April, June, September and November have 30 days; all other months except February have 31.
- R7: A year divisible by four is a leap year. February then has 29 days instead of 28. Word 10 bit 0 reads 1 for such a year.
- R8: Word 6 [2:0] is the day of week. It steps 0→1…→6→0 each time the date advances. Writing the date never changes it, and it is never checked against the date.
- R9: Values written to words 1 to 4 are stored and read back exactly as written, including non-BCD or out-of-range digits.
- R10: Word 7 [2:0] is the tick code k. The tick event repeats every TICKS_PER_SEC>>k edges, so code 0 gives 1 s and code 7 gives 1/128 s. The events are aligned so that the first one after a time load falls TICKS_PER_SEC>>k edges after the load.
- R11: Words 3 and 4 hold the alarm time and date, in the same format as words 1 and 2. The alarm event occurs on the step at which the new time and the new date both equal them. Equal time with a different date raises no event.
- R12: Word 9 holds the flags: bit 0 is alarm and bit 1 is tick. A flag is set by its event whatever word 8 holds. A flag is cleared by writing 1 to its bit; an event in the same cycle as the clear wins. `irq_alarm` and `irq_tick` are each flag ANDed with the enable in the same bit of word 8.
- R13: Words 32 to 32+SPARE_WORDS-1 are spare storage in the `sys_clk` domain. They can be written at any time, including while locked, and read back on the next `sys_clk` cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| sys_clk | input | 1 | System (bus) clock |
| sys_rst_n | input | 1 | Active-low asynchronous reset, system domain |
| rtc_clk | input | 1 | Timekeeping clock |
| rtc_rst_n | input | 1 | Active-low asynchronous reset, timekeeping domain |
| wr_en | input | 1 | Write strobe, sampled on `sys_clk` |
| addr | input | AW (6) | Word address for write and read |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr`, combinational |
| irq_alarm | output | 1 | Alarm flag AND alarm enable |
| irq_tick | output | 1 | Tick flag AND tick enable |

## Verification
A register write is due on the second `rtc_clk` rising edge after the `sys_clk` edge that captured it. The bench counts `rtc_clk` edges, notes the count at each capture, and reads one edge early (old value) and on the due edge (new value). A time step is due TICKS_PER_SEC edges after the load edge, and a tick event is due TICKS_PER_SEC>>k edges after it. Each of these is sampled on the falling `rtc_clk` edge just before and just at its due count. Flag-to-interrupt gating and the spare words are combinational or single-cycle, so they are checked right after the edge that changed them.

// File: rtl/rtc_calendar.sv
`timescale 1ns/1ps
module rtc_calendar #(
  parameter int TICKS_PER_SEC = 32768,
  parameter int SPARE_WORDS = 20,
  parameter int AW = 6,
  parameter logic [31:0] UNLOCK_KEY = 32'hA5EB1357
) (
  input  logic          sys_clk,
  input  logic          sys_rst_n,
  input  logic          rtc_clk,
  input  logic          rtc_rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] addr,
  input  logic [31:0]   wdata,
  output logic [31:0]   rdata,
  output logic          irq_alarm,
  output logic          irq_tick
);
  localparam int PW = $clog2(TICKS_PER_SEC);
  localparam int SW = $clog2(SPARE_WORDS);
  localparam int SPARE_BASE = 32;
  localparam logic [AW-1:0] A_KEY = AW'(0), A_TIME = AW'(1), A_DATE = AW'(2), A_ATIME = AW'(3),
                            A_ADATE = AW'(4), A_MODE = AW'(5), A_WDAY = AW'(6), A_TSEL = AW'(7),
                            A_IEN = AW'(8), A_FLAG = AW'(9), A_LEAP = AW'(10);

  function automatic logic [7:0] bcd_up(input logic [7:0] v);
    return (v[3:0] == 4'd9) ? {v[7:4] + 4'd1, 4'd0} : {v[7:4], v[3:0] + 4'd1};
  endfunction

  // system clock side: capture and spare storage
  logic [AW-1:0] hold_addr;
  logic [31:0]   hold_data;
  logic          tog;
  logic [31:0]   spare [SPARE_WORDS];

  wire is_spare = (int'(addr) >= SPARE_BASE) && (int'(addr) < SPARE_BASE + SPARE_WORDS);
  wire [SW-1:0] sidx = SW'(int'(addr) - SPARE_BASE);

  always_ff @(posedge sys_clk or negedge sys_rst_n)
    if (!sys_rst_n) begin
      tog       <= 1'b0;
      hold_addr <= '0;
      hold_data <= '0;
    end else if (wr_en && !is_spare) begin
      tog       <= ~tog;
      hold_addr <= addr;
      hold_data <= wdata;
    end

  always_ff @(posedge sys_clk)
    if (wr_en && is_spare) spare[sidx] <= wdata;

  // crossing into the timekeeping domain
  logic s1, s2;
  wire apply = s1 ^ s2;

  always_ff @(posedge rtc_clk or negedge rtc_rst_n)
    if (!rtc_rst_n) begin
      s1 <= 1'b0;
      s2 <= 1'b0;
    end else begin
      s1 <= tog;
      s2 <= s1;
    end

  logic          active, h24;
  logic [PW-1:0] presc;
  logic [23:0]   tm, dt, atm, adt;
  logic [2:0]    wday, tsel;
  logic [1:0]    ien, flag;

  wire wr_key   = apply && hold_addr == A_KEY && hold_data == UNLOCK_KEY;
  wire ld       = apply && active;
  wire ld_time  = ld && hold_addr == A_TIME;
  wire ld_date  = ld && hold_addr == A_DATE;
  wire ld_atime = ld && hold_addr == A_ATIME;
  wire ld_adate = ld && hold_addr == A_ADATE;
  wire ld_mode  = ld && hold_addr == A_MODE;
  wire ld_wday  = ld && hold_addr == A_WDAY;
  wire ld_tsel  = ld && hold_addr == A_TSEL;
  wire ld_ien   = ld && hold_addr == A_IEN;
  wire ld_flag  = ld && hold_addr == A_FLAG;

  // calendar arithmetic
  logic       leap;
  logic [7:0] mdays;
  assign leap = dt[20] ? (dt[19:16] == 4'h2 || dt[19:16] == 4'h6)
                       : (dt[19:16] == 4'h0 || dt[19:16] == 4'h4 || dt[19:16] == 4'h8);

  always_comb
    case (dt[15:8])
      8'h02:                      mdays = leap ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: mdays = 8'h30;
      default:                    mdays = 8'h31;
    endcase

  logic [23:0] tm_nx, dt_nx;
  logic [2:0]  wday_nx;
  logic        day_c;

  always_comb begin
    tm_nx   = tm;
    dt_nx   = dt;
    wday_nx = wday;
    day_c   = 1'b0;
    if (tm[7:0] == 8'h59) begin
      tm_nx[7:0] = 8'h00;
      if (tm[15:8] == 8'h59) begin
        tm_nx[15:8] = 8'h00;
        if (h24) begin
          if (tm[23:16] == 8'h23) begin
            tm_nx[23:16] = 8'h00;
            day_c = 1'b1;
          end else
            tm_nx[23:16] = bcd_up(tm[23:16]);
        end else begin
          case (tm[20:16])
            5'h11: begin
              tm_nx[23:16] = {2'b00, ~tm[21], 5'h12};
              day_c = tm[21];
            end
            5'h12:   tm_nx[23:16] = {2'b00, tm[21], 5'h01};
            default: tm_nx[23:16] = bcd_up(tm[23:16]);
          endcase
        end
      end else
        tm_nx[15:8] = bcd_up(tm[15:8]);
    end else
      tm_nx[7:0] = bcd_up(tm[7:0]);

    if (day_c) begin
      wday_nx = (wday == 3'd6) ? 3'd0 : wday + 3'd1;
      if (dt[7:0] == mdays) begin
        dt_nx[7:0] = 8'h01;
        if (dt[15:8] == 8'h12) begin
          dt_nx[15:8]  = 8'h01;
          dt_nx[23:16] = (dt[23:16] == 8'h99) ? 8'h00 : bcd_up(dt[23:16]);
        end else
          dt_nx[15:8] = bcd_up(dt[15:8]);
      end else
        dt_nx[7:0] = bcd_up(dt[7:0]);
    end
  end

  wire [PW-1:0] tmask = PW'((TICKS_PER_SEC - 1) >> tsel);
  wire sec_evt   = active && (presc == PW'(TICKS_PER_SEC - 1));
  wire tick_evt  = active && ((presc & tmask) == tmask);
  wire alarm_evt = sec_evt && (tm_nx == atm) && (dt_nx == adt);

  always_ff @(posedge rtc_clk or negedge rtc_rst_n)
    if (!rtc_rst_n) begin
      active <= 1'b0;
      presc  <= '0;
      tm     <= 24'h000000;
      dt     <= 24'h000101;
      atm    <= '0;
      adt    <= '0;
      h24    <= 1'b1;
      wday   <= '0;
      tsel   <= '0;
      ien    <= '0;
      flag   <= '0;
    end else begin
      if (wr_key) active <= 1'b1;
      if (active) presc <= (ld_time || sec_evt) ? '0 : presc + PW'(1);
      if (ld_time) tm <= hold_data[23:0];
      else if (sec_evt) tm <= tm_nx;
      if (ld_date) dt <= hold_data[23:0];
      else if (sec_evt) dt <= dt_nx;
      if (ld_wday) wday <= hold_data[2:0];
      else if (sec_evt) wday <= wday_nx;
      if (ld_atime) atm  <= hold_data[23:0];
      if (ld_adate) adt  <= hold_data[23:0];
      if (ld_mode)  h24  <= hold_data[0];
      if (ld_tsel)  tsel <= hold_data[2:0];
      if (ld_ien)   ien  <= hold_data[1:0];
      flag[0] <= alarm_evt | (flag[0] & ~(ld_flag & hold_data[0]));
      flag[1] <= tick_evt  | (flag[1] & ~(ld_flag & hold_data[1]));
    end

  assign irq_alarm = flag[0] & ien[0];
  assign irq_tick  = flag[1] & ien[1];

  always_comb begin
    rdata = '0;
    if (is_spare) rdata = spare[sidx];
    else
      case (addr)
        A_KEY:   rdata[0]    = active;
        A_TIME:  rdata[23:0] = tm;
        A_DATE:  rdata[23:0] = dt;
        A_ATIME: rdata[23:0] = atm;
        A_ADATE: rdata[23:0] = adt;
        A_MODE:  rdata[0]    = h24;
        A_WDAY:  rdata[2:0]  = wday;
        A_TSEL:  rdata[2:0]  = tsel;
        A_IEN:   rdata[1:0]  = ien;
        A_FLAG:  rdata[1:0]  = flag;
        A_LEAP:  rdata[0]    = leap;
        default: ;
      endcase
  end
endmodule

// File: rtl/rtc_calendar_chk.sv
`timescale 1ns/1ps
module rtc_calendar_chk (
  input logic        rtc_clk,
  input logic        rtc_rst_n,
  input logic        active,
  input logic        apply,
  input logic        sec_evt,
  input logic [23:0] tm,
  input logic [23:0] dt,
  input logic [1:0]  flag,
  input logic        clr_hit,
  input logic [1:0]  clr_bits
);
  AST_STAYS_ACTIVE: assert property (@(posedge rtc_clk) disable iff (!rtc_rst_n)
    active |=> active); // R1

  AST_UNLOCK_BY_WRITE: assert property (@(posedge rtc_clk) disable iff (!rtc_rst_n)
    $rose(active) |-> $past(apply)); // R1

  AST_LOCKED_FROZEN: assert property (@(posedge rtc_clk) disable iff (!rtc_rst_n)
    !active |=> ($stable(tm) && $stable(dt) && $stable(flag))); // R2

  AST_TIME_HOLDS: assert property (@(posedge rtc_clk) disable iff (!rtc_rst_n)
    (!sec_evt && !apply) |=> $stable(tm)); // R4

  AST_DATE_HOLDS: assert property (@(posedge rtc_clk) disable iff (!rtc_rst_n)
    (!sec_evt && !apply) |=> $stable(dt)); // R6

  AST_ALARM_STICKY: assert property (@(posedge rtc_clk) disable iff (!rtc_rst_n)
    (flag[0] && !(clr_hit && clr_bits[0])) |=> flag[0]); // R12

  AST_TICK_STICKY: assert property (@(posedge rtc_clk) disable iff (!rtc_rst_n)
    (flag[1] && !(clr_hit && clr_bits[1])) |=> flag[1]); // R12
endmodule

bind rtc_calendar rtc_calendar_chk u_chk (
  .rtc_clk  (rtc_clk),
  .rtc_rst_n(rtc_rst_n),
  .active   (active),
  .apply    (apply),
  .sec_evt  (sec_evt),
  .tm       (tm),
  .dt       (dt),
  .flag     (flag),
  .clr_hit  (ld_flag),
  .clr_bits (hold_data[1:0])
);

// File: tb/rtc_calendar_tb.sv
`timescale 1ns/1ps
module rtc_calendar_tb;
  localparam int TPS = 128;
  localparam logic [5:0] A_KEY = 0, A_TIME = 1, A_DATE = 2, A_ATIME = 3, A_ADATE = 4,
                         A_MODE = 5, A_WDAY = 6, A_TSEL = 7, A_IEN = 8, A_FLAG = 9, A_LEAP = 10;
  localparam logic [31:0] KEY = 32'hA5EB1357;

  typedef struct packed {
    logic        h24;
    logic [23:0] d;
    logic [23:0] t;
    logic [3:0]  n;
    logic [23:0] ed;
    logic [23:0] et;
  } vec_t;

  localparam int NV = 15;
  localparam vec_t VECS [NV] = '{
    '{1'b1, 24'h991231, 24'h235959, 4'd1, 24'h000101, 24'h000000},  // R6 year wrap, R4
    '{1'b1, 24'h240615, 24'h123459, 4'd1, 24'h240615, 24'h123500},  // R4
    '{1'b1, 24'h240615, 24'h005958, 4'd2, 24'h240615, 24'h010000},  // R4
    '{1'b1, 24'h240228, 24'h235959, 4'd1, 24'h240229, 24'h000000},  // R7
    '{1'b1, 24'h230228, 24'h235959, 4'd1, 24'h230301, 24'h000000},  // R7
    '{1'b1, 24'h240229, 24'h235959, 4'd1, 24'h240301, 24'h000000},  // R7
    '{1'b1, 24'h240430, 24'h235959, 4'd1, 24'h240501, 24'h000000},  // R6
    '{1'b1, 24'h240131, 24'h235959, 4'd1, 24'h240201, 24'h000000},  // R6
    '{1'b1, 24'h241231, 24'h235959, 4'd1, 24'h250101, 24'h000000},  // R6
    '{1'b0, 24'h240615, 24'h115959, 4'd1, 24'h240615, 24'h320000},  // R5
    '{1'b0, 24'h240615, 24'h315959, 4'd1, 24'h240616, 24'h120000},  // R5
    '{1'b0, 24'h240615, 24'h325959, 4'd1, 24'h240615, 24'h210000},  // R5
    '{1'b0, 24'h240615, 24'h125959, 4'd1, 24'h240615, 24'h010000},  // R5
    '{1'b1, 24'h000228, 24'h235959, 4'd1, 24'h000229, 24'h000000},  // R7
    '{1'b1, 24'h190930, 24'h235959, 4'd1, 24'h191001, 24'h000000}   // R6
  };

  logic sys_clk = 1'b0, rtc_clk = 1'b0, sys_rst_n = 1'b0, rtc_rst_n = 1'b0, wr_en = 1'b0;
  logic [5:0]  addr = '0;
  logic [31:0] wdata = '0;
  wire  [31:0] rdata;
  wire         irq_alarm, irq_tick;
  int checks = 0, errors = 0, rtc_cnt = 0, last_w = 0, base = 0;

  always #2.5 sys_clk = ~sys_clk;
  initial begin
    #1;
    forever #10 rtc_clk = ~rtc_clk;
  end
  always @(posedge rtc_clk) rtc_cnt <= rtc_cnt + 1;

  rtc_calendar #(.TICKS_PER_SEC(TPS)) u_dut (
    .sys_clk(sys_clk), .sys_rst_n(sys_rst_n), .rtc_clk(rtc_clk), .rtc_rst_n(rtc_rst_n),
    .wr_en(wr_en), .addr(addr), .wdata(wdata), .rdata(rdata),
    .irq_alarm(irq_alarm), .irq_tick(irq_tick)
  );

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, got, exp);
    end
  endtask

  task automatic wr_start(input logic [5:0] a, input logic [31:0] d);
    @(negedge sys_clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(posedge sys_clk);
    last_w = rtc_cnt;
    #1 wr_en = 1'b0;
  endtask

  task automatic wait_cnt(input int n);
    while (rtc_cnt < n) @(negedge rtc_clk);
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    wr_start(a, d);
    wait_cnt(last_w + 2);
  endtask

  task automatic chk_reg(input string tag, input logic [5:0] a, input logic [31:0] exp);
    addr = a;
    #1 check(tag, rdata, exp);
  endtask

  task automatic chk_bit(input string tag, input logic [5:0] a, input int b, input logic exp);
    addr = a;
    #1 check(tag, {31'b0, rdata[b]}, {31'b0, exp});
  endtask

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    #900000;
    checks++;
    errors++;
    $display("FAIL watchdog actual hung expected done");
    finish_run();
  end

  initial begin
    #30;
    sys_rst_n = 1'b1;
    rtc_rst_n = 1'b1;
    #3;
    chk_reg("R1 reset status", A_KEY, 32'h0);
    check("R12 reset irq", {30'b0, irq_alarm, irq_tick}, 32'h0);
    chk_reg("R2 reset time", A_TIME, 32'h0);
    chk_reg("R2 reset date", A_DATE, 32'h000101);

    // spare words while locked
    wr_start(6'd32, 32'hDEADBEEF);
    wr_start(6'd51, 32'h0BADF00D);
    chk_reg("R13 spare first", 6'd32, 32'hDEADBEEF);
    chk_reg("R13 spare last", 6'd51, 32'h0BADF00D);

    // locked: writes ignored, no counting
    wr(A_TIME, 32'h00123456);
    wr(A_IEN, 32'h3);
    wr(A_MODE, 32'h0);
    wr(A_KEY, 32'h12345678);
    wait_cnt(rtc_cnt + 2 * TPS);
    chk_reg("R2 locked time", A_TIME, 32'h0);
    chk_reg("R2 locked ien", A_IEN, 32'h0);
    chk_reg("R2 locked mode", A_MODE, 32'h1);
    chk_reg("R1 wrong key", A_KEY, 32'h0);

    wr(A_KEY, KEY);
    chk_reg("R1 unlocked", A_KEY, 32'h1);
    chk_bit("R7 year 00 leap", A_LEAP, 0, 1'b1);
    wr(A_KEY, 32'h0);
    chk_reg("R1 stays active", A_KEY, 32'h1);

    // no range check
    wr(A_TIME, 32'h00FF7A);
    chk_reg("R9 raw time", A_TIME, 32'h00FF7A);
    wr(A_DATE, 32'h99AA00);
    chk_reg("R9 raw date", A_DATE, 32'h99AA00);
    wr(A_ATIME, 32'h00EE3F);
    chk_reg("R9 raw alarm time", A_ATIME, 32'h00EE3F);

    // write latency and second restart
    wr(A_DATE, 32'h240615);
    wr(A_TIME, 32'h010203);
    wr_start(A_TIME, 32'h040506);
    wait_cnt(last_w + 1);
    chk_reg("R3 before second edge", A_TIME, 32'h010203);
    wait_cnt(last_w + 2);
    chk_reg("R3 on second edge", A_TIME, 32'h040506);
    base = last_w + 2;
    wait_cnt(base + TPS - 1);
    chk_reg("R3 second restarted", A_TIME, 32'h040506);
    wait_cnt(base + TPS);
    chk_reg("R4 one second step", A_TIME, 32'h040507);

    // vector table
    for (int i = 0; i < NV; i++) begin
      wr(A_MODE, {31'b0, VECS[i].h24});
      wr(A_DATE, {8'h0, VECS[i].d});
      wr(A_TIME, {8'h0, VECS[i].t});
      base = last_w + 2;
      wait_cnt(base + int'(VECS[i].n) * TPS);
      chk_reg($sformatf("R4/R5/R6/R7 vector %0d time", i), A_TIME, {8'h0, VECS[i].et});
      chk_reg($sformatf("R4/R5/R6/R7 vector %0d date", i), A_DATE, {8'h0, VECS[i].ed});
    end
    chk_reg("R5 mode readback", A_MODE, 32'h1);

    // leap status
    wr(A_DATE, 32'h240101); chk_bit("R7 leap 24", A_LEAP, 0, 1'b1);
    wr(A_DATE, 32'h230101); chk_bit("R7 leap 23", A_LEAP, 0, 1'b0);
    wr(A_DATE, 32'h960101); chk_bit("R7 leap 96", A_LEAP, 0, 1'b1);
    wr(A_DATE, 32'h900101); chk_bit("R7 leap 90", A_LEAP, 0, 1'b0);

    // weekday
    wr(A_WDAY, 32'h6);
    wr(A_DATE, 32'h240615);
    chk_reg("R8 date write keeps weekday", A_WDAY, 32'h6);
    wr(A_TIME, 32'h235959);
    base = last_w + 2;
    wait_cnt(base + TPS);
    chk_reg("R8 weekday wrap", A_WDAY, 32'h0);
    wr(A_TIME, 32'h235959);
    base = last_w + 2;
    wait_cnt(base + TPS);
    chk_reg("R8 weekday step", A_WDAY, 32'h1);

    // tick code 3
    wr(A_IEN, 32'h0);
    wr(A_TSEL, 32'h3);
    wr(A_TIME, 32'h100000);
    base = last_w + 2;
    wr(A_FLAG, 32'h3);
    wait_cnt(base + TPS / 8 - 1);
    chk_bit("R10 code3 before", A_FLAG, 1, 1'b0);
    wait_cnt(base + TPS / 8);
    chk_bit("R10 code3 due", A_FLAG, 1, 1'b1);
    check("R12 tick gated off", {31'b0, irq_tick}, 32'h0);
    wr(A_IEN, 32'h2);
    check("R12 tick irq", {31'b0, irq_tick}, 32'h1);

    // tick code 0
    wr(A_TSEL, 32'h0);
    wr(A_TIME, 32'h100000);
    base = last_w + 2;
    wr(A_FLAG, 32'h2);
    wait_cnt(base + TPS - 1);
    chk_bit("R10 code0 before", A_FLAG, 1, 1'b0);
    check("R12 tick irq cleared", {31'b0, irq_tick}, 32'h0);
    wait_cnt(base + TPS);
    chk_bit("R10 code0 due", A_FLAG, 1, 1'b1);

    // tick code 7: event every edge beats the clear
    wr(A_TSEL, 32'h7);
    wr(A_FLAG, 32'h2);
    chk_bit("R12 event wins over clear", A_FLAG, 1, 1'b1);
    wr(A_TSEL, 32'h0);

    // alarm
    wr(A_IEN, 32'h1);
    wr(A_ADATE, 32'h240615);
    wr(A_ATIME, 32'h100005);
    wr(A_DATE, 32'h240615);
    wr(A_TIME, 32'h100003);
    base = last_w + 2;
    wr(A_FLAG, 32'h1);
    wait_cnt(base + TPS);
    chk_bit("R11 alarm not yet", A_FLAG, 0, 1'b0);
    wait_cnt(base + 2 * TPS);
    chk_bit("R11 alarm match", A_FLAG, 0, 1'b1);
    check("R12 alarm irq", {31'b0, irq_alarm}, 32'h1);
    wr(A_FLAG, 32'h1);
    chk_bit("R12 alarm clear", A_FLAG, 0, 1'b0);
    check("R12 alarm irq clear", {31'b0, irq_alarm}, 32'h0);

    wr(A_ADATE, 32'h240616);
    wr(A_TIME, 32'h100004);
    base = last_w + 2;
    wait_cnt(base + TPS);
    chk_reg("R11 time reached", A_TIME, 32'h100005);
    chk_bit("R11 date mismatch", A_FLAG, 0, 1'b0);

    chk_reg("R13 spare kept", 6'd32, 32'hDEADBEEF);
    finish_run();
  end
endmodule